// File: doc/BRIEF.md
# Power-Fail Lockout and Time Save Controller

This block guards a host register interface against a failing main supply. It watches an active-low power-fail input, qualifies it over a timed delay, and then shuts the host strobes off so that no half-powered bus cycle can corrupt the register file behind it. A bus cycle that is already running when the delay expires is allowed to finish. Lockout takes hold only once the bus has gone idle.

At the moment lockout takes hold, the block freezes a copy of the live time counters. It then writes that copy, one counter per cycle, into a time-save store, so the time of the failure is preserved. In the same cycle it sends a one-cycle event to the interrupt logic. When the power-fail input returns high, the lockout clears on the first idle bus cycle and host access resumes.

The delay runs off a prescaled tick derived from the block clock. When the programmed delay value is zero, a default window applies. That window spans from (DEF_SLOTS-1) to DEF_SLOTS coarse slots, because the free-running slot counter is not aligned to the falling edge. With a nonzero value, the delay is that many fine ticks.

Top module: `pfl_lockout_ctrl`

## Requirements
- R1: After reset, lockout, pf_event and save_we are 0, and the gated host strobes follow the host inputs.
- R2: While not locked out, bus_cs_n_o, bus_rd_n_o, bus_wr_n_o and bus_addr_o equal cs_n, rd_n, wr_n and addr. data_oe is 1 exactly when cs_n and rd_n are both 0 and the synchronised power-fail level is high.
- R3: With lock_dly equal to 0, lockout rises no sooner than (DEF_SLOTS-1)*SLOT_TICKS*TICK_DIV clocks after pfail_n falls, and no later than DEF_SLOTS*SLOT_TICKS*TICK_DIV plus 6 clocks after it falls.
- R4: With lock_dly equal to N and N nonzero, lockout rises no sooner than (N-1)*TICK_DIV clocks after pfail_n falls, and no later than N*TICK_DIV plus 6 clocks after it falls.
- R5: While lockout is 1, bus_cs_n_o, bus_rd_n_o and bus_wr_n_o are held at 1, bus_addr_o is held at 0 and data_oe is 0, whatever the host drives. Host activity in this state has no effect on these outputs.
- R6: A bus cycle counts as active when cs_n is 0 and rd_n or wr_n is 0. If a cycle is active when the delay expires, lockout stays 0 until the cycle ends. Lockout then rises on the next clock.
- R7: data_oe is 0 whenever the synchronised power-fail level is low, even during a read cycle that is still allowed to complete.
- R8: On lockout entry, time_i is sampled at the clock edge where lockout rises. Entry k of time_i occupies bits [k*CNT_W +: CNT_W]. Starting in the cycle where lockout is first 1, the block drives NUM_CNT consecutive save_we cycles with save_idx = 0, 1, ..., NUM_CNT-1, and each save_data equals the sampled entry at that index. Changes to time_i after that edge are not reflected in these writes.
- R9: pf_event is 1 for exactly one cycle per lockout entry, in the first cycle where lockout is 1.
- R10: If pfail_n returns high before the delay expires, no lockout and no pf_event occur.
- R11: When pfail_n is high again, lockout clears only once no bus cycle is active, and pass-through access then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pfail_n | input | 1 | Power-fail sense, low means failing (asynchronous) |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| addr | input | AW | Host register address |
| lock_dly | input | DLY_W | Lockout delay in fine ticks, 0 selects the default window |
| time_i | input | NUM_CNT*CNT_W | Live time counters, entry k at bits [k*CNT_W +: CNT_W] |
| bus_cs_n_o | output | 1 | Gated chip select to the register file |
| bus_rd_n_o | output | 1 | Gated read strobe |
| bus_wr_n_o | output | 1 | Gated write strobe |
| bus_addr_o | output | AW | Gated address |
| data_oe | output | 1 | Data bus drive enable, 0 means high impedance |
| lockout | output | 1 | Lockout flag |
| pf_event | output | 1 | One-cycle power-fail event toward interrupt logic |
| save_we | output | 1 | Time-save store write strobe |
| save_idx | output | IDX_W | Time-save entry index |
| save_data | output | CNT_W | Time-save entry data |

## Verification
The delay qualifier is exercised in four ways. The default window and a programmed delay both show that the mode select picks the right counting base. A short low pulse that returns before expiry separates a qualified failure from a glitch. A read held across the expiry point separates the completion grace from an immediate cutoff, and also checks that the drive enable drops as soon as the power sense is low. The time-save path is checked against a counter snapshot that the bench changes right after lockout. This shows that the block captures the counters at entry instead of copying them live. A recovery with the strobes still asserted shows that release waits for an idle bus.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_PEND  = 2'd2,
    ST_LOCK  = 2'd3
  } pfl_state_e;

endpackage

// File: rtl/pfl_sync2.sv
// Two-stage synchroniser with a selectable reset level.
module pfl_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

endmodule

// File: rtl/pfl_tick_gen.sv
// Free-running fine tick (every TICK_DIV clocks) and coarse slot tick
// (every SLOT_TICKS fine ticks).
module pfl_tick_gen #(
  parameter int TICK_DIV   = 33,
  parameter int SLOT_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic ms_tick,
  output logic slot_tick
);

  localparam int PW = (TICK_DIV   > 1) ? $clog2(TICK_DIV)   : 1;
  localparam int SW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;

  logic [PW-1:0] pre_q, pre_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          slot_end;

  assign ms_tick   = (pre_q == PW'(TICK_DIV - 1));
  assign slot_end  = (slot_q == SW'(SLOT_TICKS - 1));
  assign slot_tick = ms_tick && slot_end;

  always_comb begin
    pre_d  = ms_tick ? '0 : pre_q + 1'b1;
    slot_d = slot_q;
    if (ms_tick) begin
      slot_d = slot_end ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      slot_q <= '0;
    end else begin
      pre_q  <= pre_d;
      slot_q <= slot_d;
    end
  end

endmodule

// File: rtl/pfl_delay_qual.sv
// Qualifies the synchronised power-fail level over the delay window,
// waits for the bus to go idle, and holds the lockout state.
module pfl_delay_qual
  import pfl_pkg::*;
#(
  parameter int DLY_W     = 6,
  parameter int DEF_SLOTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pf_ok,
  input  logic             bus_busy,
  input  logic             ms_tick,
  input  logic             slot_tick,
  input  logic [DLY_W-1:0] lock_dly,
  output logic             lockout,
  output logic             pf_event,
  output logic             save_go
);

  pfl_state_e       state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0] cnt_inc;
  logic [DLY_W-1:0] target;
  logic             prog_mode;
  logic             step;
  logic             hit;
  logic             enter_lock;
  logic             ev_q;

  assign prog_mode = (lock_dly != '0);
  assign target    = prog_mode ? lock_dly : DLY_W'(DEF_SLOTS);
  assign step      = prog_mode ? ms_tick : slot_tick;
  assign cnt_inc   = cnt_q + 1'b1;
  assign hit       = step && (cnt_inc == target);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (!pf_ok) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (pf_ok) begin
          state_d = ST_IDLE;
        end else if (hit) begin
          state_d = bus_busy ? ST_PEND : ST_LOCK;
        end else if (step) begin
          cnt_d = cnt_inc;
        end
      end
      ST_PEND: begin
        if (pf_ok)          state_d = ST_IDLE;
        else if (!bus_busy) state_d = ST_LOCK;
      end
      ST_LOCK: begin
        if (pf_ok && !bus_busy) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign enter_lock = (state_d == ST_LOCK) && (state_q != ST_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ev_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ev_q    <= enter_lock;
    end
  end

  assign lockout  = (state_q == ST_LOCK);
  assign pf_event = ev_q;
  assign save_go  = enter_lock;

endmodule

// File: rtl/pfl_time_save.sv
// Snapshots the live counters on save_go, then writes them out one per cycle.
module pfl_time_save #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 8,
  parameter int IDX_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     save_go,
  input  logic [NUM_CNT*CNT_W-1:0] time_i,
  output logic                     save_we,
  output logic [IDX_W-1:0]         save_idx,
  output logic [CNT_W-1:0]         save_data
);

  localparam int TW = NUM_CNT * CNT_W;

  logic [TW-1:0]    snap_q, snap_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             busy_q, busy_d;

  always_comb begin
    snap_d = snap_q;
    idx_d  = idx_q;
    busy_d = busy_q;
    if (save_go) begin
      snap_d = time_i;
      idx_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (idx_q == IDX_W'(NUM_CNT - 1)) begin
        busy_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      snap_q <= snap_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
    end
  end

  always_comb begin
    save_data = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (idx_q == IDX_W'(k)) save_data = snap_q[k*CNT_W +: CNT_W];
    end
  end

  assign save_we  = busy_q;
  assign save_idx = idx_q;

endmodule

// File: rtl/pfl_lockout_ctrl.sv
module pfl_lockout_ctrl #(
  parameter int AW         = 5,
  parameter int DLY_W      = 6,
  parameter int TICK_DIV   = 33,
  parameter int SLOT_TICKS = 32,
  parameter int DEF_SLOTS  = 2,
  parameter int NUM_CNT    = 8,
  parameter int CNT_W      = 8,
  parameter int IDX_W      = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pfail_n,
  input  logic                     cs_n,
  input  logic                     rd_n,
  input  logic                     wr_n,
  input  logic [AW-1:0]            addr,
  input  logic [DLY_W-1:0]         lock_dly,
  input  logic [NUM_CNT*CNT_W-1:0] time_i,
  output logic                     bus_cs_n_o,
  output logic                     bus_rd_n_o,
  output logic                     bus_wr_n_o,
  output logic [AW-1:0]            bus_addr_o,
  output logic                     data_oe,
  output logic                     lockout,
  output logic                     pf_event,
  output logic                     save_we,
  output logic [IDX_W-1:0]         save_idx,
  output logic [CNT_W-1:0]         save_data
);

  logic rst_sync_n;
  logic pf_ok;
  logic ms_tick, slot_tick;
  logic bus_busy;
  logic save_go;

  pfl_sync2 #(.RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  pfl_sync2 #(.RST_VAL(1'b1)) u_pf_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pfail_n), .q(pf_ok)
  );

  pfl_tick_gen #(.TICK_DIV(TICK_DIV), .SLOT_TICKS(SLOT_TICKS)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .ms_tick(ms_tick), .slot_tick(slot_tick)
  );

  assign bus_busy = !cs_n && (!rd_n || !wr_n);

  pfl_delay_qual #(.DLY_W(DLY_W), .DEF_SLOTS(DEF_SLOTS)) u_qual (
    .clk(clk), .rst_n(rst_sync_n), .pf_ok(pf_ok), .bus_busy(bus_busy),
    .ms_tick(ms_tick), .slot_tick(slot_tick), .lock_dly(lock_dly),
    .lockout(lockout), .pf_event(pf_event), .save_go(save_go)
  );

  pfl_time_save #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_save (
    .clk(clk), .rst_n(rst_sync_n), .save_go(save_go), .time_i(time_i),
    .save_we(save_we), .save_idx(save_idx), .save_data(save_data)
  );

  // Host gating: strobes forced inactive and address parked while locked.
  assign bus_cs_n_o = cs_n | lockout;
  assign bus_rd_n_o = rd_n | lockout;
  assign bus_wr_n_o = wr_n | lockout;
  assign bus_addr_o = lockout ? '0 : addr;
  assign data_oe    = !lockout && pf_ok && !cs_n && !rd_n;

endmodule

// File: rtl/pfl_lockout_chk.sv
module pfl_lockout_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pf_ok,
  input logic             cs_n,
  input logic             rd_n,
  input logic             wr_n,
  input logic             bus_cs_n_o,
  input logic             bus_rd_n_o,
  input logic             bus_wr_n_o,
  input logic             data_oe,
  input logic             lockout,
  input logic             pf_event,
  input logic             save_we,
  input logic [IDX_W-1:0] save_idx
);

  // R5: strobes blocked and bus released during lockout
  a_r5_strobes_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> (bus_cs_n_o && bus_rd_n_o && bus_wr_n_o && !data_oe));

  // R6: lockout never begins on top of an active bus cycle
  a_r6_idle_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockout) |-> $past(cs_n || (rd_n && wr_n)));

  // R7: no data drive while the power sense is low
  a_r7_oe_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_ok |-> !data_oe);

  // R9: event coincides with lockout entry and lasts one cycle
  a_r9_event_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
    pf_event |-> $rose(lockout));

  a_r9_event_single: assert property (@(posedge clk) disable iff (!rst_n)
    pf_event |=> !pf_event);

  // R8: consecutive save writes step the index by one
  a_r8_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (save_we && $past(save_we)) |-> (save_idx == $past(save_idx) + 1'b1));

endmodule

bind pfl_lockout_ctrl pfl_lockout_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pf_ok(pf_ok), .cs_n(cs_n), .rd_n(rd_n),
  .wr_n(wr_n), .bus_cs_n_o(bus_cs_n_o), .bus_rd_n_o(bus_rd_n_o),
  .bus_wr_n_o(bus_wr_n_o), .data_oe(data_oe), .lockout(lockout),
  .pf_event(pf_event), .save_we(save_we), .save_idx(save_idx)
);

// File: tb/pfl_lockout_ctrl_tb.sv
module pfl_lockout_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 5;
  localparam int DLY_W      = 6;
  localparam int DIV        = 4;
  localparam int SLOT       = 8;
  localparam int DSLOTS     = 2;
  localparam int NC         = 8;
  localparam int CW         = 8;
  localparam int IW         = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pfail_n, cs_n, rd_n, wr_n;
  logic [AW-1:0]    addr;
  logic [DLY_W-1:0] lock_dly;
  logic [NC*CW-1:0] time_i;
  logic             bus_cs_n_o, bus_rd_n_o, bus_wr_n_o, data_oe;
  logic [AW-1:0]    bus_addr_o;
  logic             lockout, pf_event, save_we;
  logic [IW-1:0]    save_idx;
  logic [CW-1:0]    save_data;

  int n_chk = 0;
  int n_bad = 0;
  int ev_cnt = 0;
  int rise_cnt = 0;
  int wr_cnt = 0;
  logic prev_lock = 1'b0;
  logic [CW-1:0] save_log [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  pfl_lockout_ctrl #(
    .AW(AW), .DLY_W(DLY_W), .TICK_DIV(DIV), .SLOT_TICKS(SLOT),
    .DEF_SLOTS(DSLOTS), .NUM_CNT(NC), .CNT_W(CW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pfail_n(pfail_n), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .addr(addr), .lock_dly(lock_dly), .time_i(time_i),
    .bus_cs_n_o(bus_cs_n_o), .bus_rd_n_o(bus_rd_n_o), .bus_wr_n_o(bus_wr_n_o),
    .bus_addr_o(bus_addr_o), .data_oe(data_oe), .lockout(lockout),
    .pf_event(pf_event), .save_we(save_we), .save_idx(save_idx),
    .save_data(save_data)
  );

  // Output monitor, sampled mid-cycle.
  always @(negedge clk) begin
    if (pf_event) ev_cnt++;
    if (lockout && !prev_lock) rise_cnt++;
    prev_lock = lockout;
    if (save_we) begin
      save_log[save_idx] = save_data;
      wr_cnt++;
    end
  end

  function automatic logic [NC*CW-1:0] mk_time(input logic [CW-1:0] base);
    logic [NC*CW-1:0] v;
    for (int k = 0; k < NC; k++) v[k*CW +: CW] = base + CW'(k * 3);
    return v;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Falls pfail_n and returns cycles until lockout, or -1 on timeout.
  task automatic fail_and_measure(output int n);
    pfail_n = 1'b0;
    n = 0;
    while (!lockout && n < 400) begin
      @(negedge clk);
      n++;
    end
    if (!lockout) n = -1;
  endtask

  task automatic check_save(input logic [NC*CW-1:0] exp_t, input string tag);
    cyc(NC + 3);
    chk(wr_cnt == NC, tag, wr_cnt, NC);
    for (int k = 0; k < NC; k++)
      chk(save_log[k] == exp_t[k*CW +: CW], tag, save_log[k], exp_t[k*CW +: CW]);
  endtask

  task automatic recover();
    pfail_n = 1'b1;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    cyc(6);
  endtask

  task automatic t_reset();
    chk(lockout == 1'b0, "R1 lockout", lockout, 0);
    chk(pf_event == 1'b0, "R1 pf_event", pf_event, 0);
    chk(save_we == 1'b0, "R1 save_we", save_we, 0);
    chk(bus_cs_n_o == 1'b1, "R1 cs pass", bus_cs_n_o, 1);
  endtask

  task automatic t_passthru();
    cs_n = 1'b0; rd_n = 1'b0; addr = 5'd19;
    cyc(1);
    chk(bus_cs_n_o == 1'b0 && bus_rd_n_o == 1'b0, "R2 read strobes", bus_rd_n_o, 0);
    chk(bus_addr_o == 5'd19, "R2 addr", bus_addr_o, 19);
    chk(data_oe == 1'b1, "R2 read oe", data_oe, 1);
    rd_n = 1'b1; wr_n = 1'b0; addr = 5'd6;
    cyc(1);
    chk(bus_wr_n_o == 1'b0 && bus_addr_o == 5'd6, "R2 write pass", bus_addr_o, 6);
    chk(data_oe == 1'b0, "R2 write oe", data_oe, 0);
    cs_n = 1'b1; wr_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_prog_delay();
    int n;
    int ev0;
    logic [NC*CW-1:0] t1;
    lock_dly = 6'd5;
    t1 = mk_time(8'h21);
    time_i = t1;
    ev0 = ev_cnt;
    wr_cnt = 0;
    fail_and_measure(n);
    time_i = mk_time(8'hA0);
    chk(n >= 4 * DIV && n <= 5 * DIV + 6, "R4 programmed window", n, 5 * DIV);
    cyc(3);
    chk(ev_cnt == ev0 + 1, "R9 one event", ev_cnt - ev0, 1);
    check_save(t1, "R8 snapshot prog");
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = 5'd31;
    cyc(2);
    chk(bus_cs_n_o && bus_rd_n_o && bus_wr_n_o, "R5 strobes held", bus_cs_n_o, 1);
    chk(bus_addr_o == '0, "R5 addr parked", bus_addr_o, 0);
    chk(data_oe == 1'b0, "R5 oe off", data_oe, 0);
    recover();
    chk(lockout == 1'b0, "R11 cleared", lockout, 1'b0);
  endtask

  task automatic t_default_delay();
    int n;
    logic [NC*CW-1:0] t1;
    lock_dly = '0;
    t1 = mk_time(8'h55);
    time_i = t1;
    wr_cnt = 0;
    cyc(3);
    fail_and_measure(n);
    time_i = mk_time(8'h07);
    chk(n >= (DSLOTS - 1) * SLOT * DIV && n <= DSLOTS * SLOT * DIV + 6,
        "R3 default window", n, DSLOTS * SLOT * DIV);
    check_save(t1, "R8 snapshot default");
    recover();
  endtask

  task automatic t_glitch();
    int r0, e0;
    lock_dly = 6'd10;
    r0 = rise_cnt; e0 = ev_cnt;
    pfail_n = 1'b0;
    cyc(12);
    pfail_n = 1'b1;
    cyc(80);
    chk(rise_cnt == r0, "R10 no lockout", rise_cnt - r0, 0);
    chk(ev_cnt == e0, "R10 no event", ev_cnt - e0, 0);
  endtask

  task automatic t_inflight();
    lock_dly = 6'd3;
    cs_n = 1'b0; rd_n = 1'b0; addr = 5'd2;
    cyc(1);
    pfail_n = 1'b0;
    cyc(40);
    chk(lockout == 1'b0, "R6 held off during read", lockout, 0);
    chk(bus_rd_n_o == 1'b0, "R6 read completes", bus_rd_n_o, 0);
    chk(data_oe == 1'b0, "R7 oe off with low power", data_oe, 0);
    cs_n = 1'b1; rd_n = 1'b1;
    cyc(1);
    chk(lockout == 1'b1, "R6 lock after idle", lockout, 1);
    // Recovery with a cycle still asserted must wait for idle.
    cyc(NC + 2);
    cs_n = 1'b0; rd_n = 1'b0;
    pfail_n = 1'b1;
    cyc(10);
    chk(lockout == 1'b1, "R11 waits for idle", lockout, 1);
    chk(bus_rd_n_o == 1'b1, "R5 read ignored", bus_rd_n_o, 1);
    cs_n = 1'b1; rd_n = 1'b1;
    cyc(2);
    chk(lockout == 1'b0, "R11 released", lockout, 0);
    cs_n = 1'b0; rd_n = 1'b0; addr = 5'd9;
    cyc(1);
    chk(bus_rd_n_o == 1'b0 && bus_addr_o == 5'd9, "R11 access resumes", bus_addr_o, 9);
    cs_n = 1'b1; rd_n = 1'b1;
    cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pfail_n = 1'b1;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr = '0; lock_dly = '0; time_i = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_passthru();
    t_prog_delay();
    t_default_delay();
    t_glitch();
    t_inflight();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule